// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector with Four-Way Mode Decode

This block compares the pulse trains of two frequency dividers in a synthesizer loop, one fed by the reference oscillator and one fed by the voltage-controlled oscillator. It asks a downstream charge pump to source current (`up`) while the reference edge leads and to sink current (`dn`) while the oscillator edge leads. When neither request is active, the pump output floats. Once both requests have been raised, they are both withdrawn one clock later. This reset path keeps the detector free of a dead zone around zero phase error.

A two-bit mode input stands for a control pin that has four states. The mode selects the pump current level, switches the pump off, clamps the loop-amplifier input to ground, and chooses which divider's pulse train appears on a test output. The test signal toggles once per divider edge, which gives a 50 % duty square wave at the divided rate. All outputs are digital. The analog pump and the loop filter live outside the block. Both divider inputs are assumed to be synchronous to `clk`, and each is held for at least one clock per pulse.

Top module: `tri_state_pfd`

## Requirements
- R1: A rising edge on `ref_in` (sampled high after being sampled low) sets the up request at the next clock edge. The request then stays set until the clear described in R3.
- R2: A rising edge on `osc_in` sets the down request at the next clock edge. The request then stays set until the clear described in R3.
- R3: When the up and down requests are both set, both are cleared at the following clock edge. A divider edge that arrives in that clearing cycle does not set a request.
- R4: Mode code 2'b00 gives `cur_hi`=0, `pump_en`=1, `amp_clamp`=0. Mode code 2'b01 gives `cur_hi`=1, `pump_en`=1, `amp_clamp`=0. At most one of `cur_hi`, `!pump_en` and `amp_clamp` is ever true.
- R5: Mode code 2'b10 gives `pump_en`=0 and forces `up` and `dn` low. The request state keeps evolving, and it reappears on `up`/`dn` once the pump is enabled again.
- R6: Mode code 2'b11 gives `amp_clamp`=1, `pump_en`=1 and `cur_hi`=0.
- R7: Each divider has a toggle bit that flips on every rising edge of that divider, including edges that arrive in a clearing cycle. `test_out` shows the oscillator toggle bit in mode 2'b10 and the reference toggle bit in mode 2'b11. In modes 2'b00 and 2'b01, `test_out` is 0.
- R8: While `rst_n` is low at a clock edge, every output becomes 0, both toggle bits become 0, and the pump is disabled until the first mode is registered after reset.
- R9: A change on `mode`, `ref_in` or `osc_in` made before a clock edge shows on the outputs right after that edge, with a latency of one register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference-divider pulse train |
| osc_in | input | 1 | Oscillator-divider pulse train |
| mode | input | 2 | Four-state control: 00 low current, 01 high current, 10 pump off / oscillator test, 11 clamp / reference test |
| up | output | 1 | Source-current request to the charge pump |
| dn | output | 1 | Sink-current request to the charge pump |
| cur_hi | output | 1 | 1 selects the higher pump current |
| pump_en | output | 1 | 1 enables the charge pump |
| amp_clamp | output | 1 | 1 grounds the loop-amplifier input |
| test_out | output | 1 | Toggled copy of the selected divider, or 0 |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. This holds for request setting, the mode decode and the test-output toggles. The one exception is the withdrawal of a both-set pair, which lands one edge later still. The driver applies each stimulus at a falling edge and queues the outputs expected after the next rising edge. The monitor compares them one nanosecond after that rising edge, when every register on the path has settled. Multi-cycle behaviour is covered by a run of one-cycle steps, each with its own expectation: requests held across idle cycles, the clearing cycle, an edge lost in that cycle, and state that keeps running while the pump is masked.

// File: rtl/tpfd_pkg.sv
// Shared types for the three-state phase detector.
// Assumes a two-bit mode code; channel indices fix which edge unit is the reference.
package tpfd_pkg;

    localparam int NUM_CH  = 2;
    localparam int REF_CH  = 0;
    localparam int OSC_CH  = 1;
    localparam int MODE_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_LOW  = 2'b00,
        MODE_HIGH = 2'b01,
        MODE_MID  = 2'b10,
        MODE_OPEN = 2'b11
    } pfd_mode_e;

    typedef enum logic [1:0] {
        TSEL_NONE = 2'b00,
        TSEL_OSC  = 2'b01,
        TSEL_REF  = 2'b10
    } test_sel_e;

    typedef struct packed {
        logic      cur_hi;
        logic      pump_en;
        logic      amp_clamp;
        test_sel_e test_sel;
    } mode_ctl_t;

    // Turns a mode code into the control settings it stands for.
    function automatic mode_ctl_t decode_mode(input logic [MODE_W-1:0] code);
        mode_ctl_t c;
        c = '{cur_hi: 1'b0, pump_en: 1'b1, amp_clamp: 1'b0, test_sel: TSEL_NONE};
        case (pfd_mode_e'(code))
            MODE_HIGH: c.cur_hi = 1'b1;
            MODE_MID: begin
                c.pump_en  = 1'b0;
                c.test_sel = TSEL_OSC;
            end
            MODE_OPEN: begin
                c.amp_clamp = 1'b1;
                c.test_sel  = TSEL_REF;
            end
            default: c.cur_hi = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tpfd_edge.sv
// Rising-edge detection and toggle divider for each divider input.
// Assumes the inputs are synchronous to clk; one channel per bit of sig_in.
module tpfd_edge
    import tpfd_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] sig_in,
    output logic [CH-1:0] rise,
    output logic [CH-1:0] tgl
);

    logic [CH-1:0] prev_q;
    logic [CH-1:0] tgl_q;

    for (genvar i = 0; i < CH; i++) begin : g_ch
        // Remembers the last sampled level of the channel.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= sig_in[i];
        end

        assign rise[i] = sig_in[i] & ~prev_q[i];

        // Flips once per detected edge to form a half-rate square wave.
        always_ff @(posedge clk) begin
            if (!rst_n)       tgl_q[i] <= 1'b0;
            else if (rise[i]) tgl_q[i] <= ~tgl_q[i];
        end
    end

    assign tgl = tgl_q;

endmodule

// File: rtl/tpfd_core.sv
// Three-state request machine: up/down latches with a shared clear.
// Assumes edge strobes last one cycle; edges arriving while both are set are dropped.
module tpfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic osc_rise,
    output logic up_st,
    output logic dn_st
);

    logic clr;
    assign clr = up_st & dn_st;

    // Latches the up request on a reference edge; the clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)   up_st <= 1'b0;
        else if (clr) up_st <= 1'b0;
        else          up_st <= up_st | ref_rise;
    end

    // Latches the down request on an oscillator edge; the clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)   dn_st <= 1'b0;
        else if (clr) dn_st <= 1'b0;
        else          dn_st <= dn_st | osc_rise;
    end

endmodule

// File: rtl/tpfd_mode.sv
// Registers the decoded mode so the controls change only at clock edges.
// Assumes the mode input is static or synchronous; reset leaves the pump disabled.
module tpfd_mode
    import tpfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    output mode_ctl_t         ctl
);

    // Captures the decoded control word every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl <= '0;
        else        ctl <= decode_mode(mode);
    end

endmodule

// File: rtl/tri_state_pfd.sv
// Top: phase-frequency detector with pump masking and a test-signal selector.
// Assumes both divider inputs and the mode input are synchronous to clk.
module tri_state_pfd
    import tpfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              osc_in,
    input  logic [MODE_W-1:0] mode,
    output logic              up,
    output logic              dn,
    output logic              cur_hi,
    output logic              pump_en,
    output logic              amp_clamp,
    output logic              test_out
);

    logic [NUM_CH-1:0] div_in;
    logic [NUM_CH-1:0] div_rise;
    logic [NUM_CH-1:0] div_tgl;
    logic              up_state;
    logic              dn_state;
    mode_ctl_t         ctl;

    assign div_in[REF_CH] = ref_in;
    assign div_in[OSC_CH] = osc_in;

    tpfd_edge #(.CH(NUM_CH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (div_in),
        .rise   (div_rise),
        .tgl    (div_tgl)
    );

    tpfd_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (div_rise[REF_CH]),
        .osc_rise (div_rise[OSC_CH]),
        .up_st    (up_state),
        .dn_st    (dn_state)
    );

    tpfd_mode u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .ctl   (ctl)
    );

    // Masks the pump requests when the pump is switched off.
    always_comb begin
        up = up_state & ctl.pump_en;
        dn = dn_state & ctl.pump_en;
    end

    // Steers the chosen divider toggle onto the test output.
    always_comb begin
        case (ctl.test_sel)
            TSEL_OSC: test_out = div_tgl[OSC_CH];
            TSEL_REF: test_out = div_tgl[REF_CH];
            default:  test_out = 1'b0;
        endcase
    end

    assign cur_hi    = ctl.cur_hi;
    assign pump_en   = ctl.pump_en;
    assign amp_clamp = ctl.amp_clamp;

endmodule

// File: rtl/tri_state_pfd_chk.sv
// Property checker for tri_state_pfd, attached with bind.
// Assumes it sees the request state through the bind connection.
module tri_state_pfd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_in,
    input logic [1:0] mode,
    input logic       up,
    input logic       dn,
    input logic       cur_hi,
    input logic       pump_en,
    input logic       amp_clamp,
    input logic       test_out,
    input logic       up_st,
    input logic       dn_st
);

    AST_PAIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_st && dn_st) |=> (!up_st && !dn_st)); // R3

    AST_UP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_st && !dn_st) |=> up_st); // R1

    AST_REF_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ref_in) && !(up_st && dn_st)) |=> up_st); // R1

    AST_PUMP_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_en |-> (!up && !dn)); // R5

    AST_OPEN_CLAMPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (amp_clamp && pump_en && !cur_hi)); // R6

    AST_MID_PUMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> !pump_en); // R5

    AST_DECODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cur_hi, !pump_en, amp_clamp})); // R4

    AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_en && !amp_clamp) |-> !test_out); // R7

endmodule

bind tri_state_pfd tri_state_pfd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_in    (ref_in),
    .mode      (mode),
    .up        (up),
    .dn        (dn),
    .cur_hi    (cur_hi),
    .pump_en   (pump_en),
    .amp_clamp (amp_clamp),
    .test_out  (test_out),
    .up_st     (up_state),
    .dn_st     (dn_state)
);

// File: tb/tri_state_pfd_tb.sv
`timescale 1ns/1ps
module tri_state_pfd_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       osc_in = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       up, dn, cur_hi, pump_en, amp_clamp, test_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [5:0] val;   // {up, dn, cur_hi, pump_en, amp_clamp, test_out}
        string      req;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    tri_state_pfd u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .osc_in    (osc_in),
        .mode      (mode),
        .up        (up),
        .dn        (dn),
        .cur_hi    (cur_hi),
        .pump_en   (pump_en),
        .amp_clamp (amp_clamp),
        .test_out  (test_out)
    );

    // Expected {cur_hi, pump_en, amp_clamp} per mode code (R4, R5, R6).
    function automatic logic [2:0] mode_exp(input logic [1:0] m);
        case (m)
            2'b00:   return 3'b010;
            2'b01:   return 3'b110;
            2'b10:   return 3'b000;
            default: return 3'b011;
        endcase
    endfunction

    // Driver: applies one step at a falling edge and queues the result due after the next rising edge.
    task automatic step(input logic r, input logic o, input logic [1:0] m,
                        input logic e_up, input logic e_dn, input logic e_t,
                        input string req);
        exp_t it;
        @(negedge clk);
        ref_in = r;
        osc_in = o;
        mode   = m;
        it.val = {e_up, e_dn, mode_exp(m), e_t};
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compares outputs one nanosecond after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() != 0) begin
            exp_t it;
            logic [5:0] act;
            it  = sb_q.pop_front();
            act = {up, dn, cur_hi, pump_en, amp_clamp, test_out};
            checks++;
            if (act !== it.val) begin
                fails++;
                $display("FAIL %s: {up,dn,cur_hi,pump_en,clamp,test} actual %b expected %b",
                         it.req, act, it.val);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({up, dn, cur_hi, pump_en, amp_clamp, test_out} !== 6'b0) begin
            fails++;
            $display("FAIL R8 reset: actual %b expected 000000",
                     {up, dn, cur_hi, pump_en, amp_clamp, test_out});
        end
        rst_n = 1'b1;

        // r1_ reference leads
        step(0, 0, 2'b00, 0, 0, 0, "R4 low mode idle");
        step(1, 0, 2'b00, 1, 0, 0, "R1 ref edge sets up");
        step(1, 0, 2'b00, 1, 0, 0, "R1 held level no new edge");
        step(0, 0, 2'b00, 1, 0, 0, "R1 up persists");
        step(0, 1, 2'b00, 1, 1, 0, "R2 osc edge sets dn");
        step(0, 1, 2'b00, 0, 0, 0, "R3 pair cleared");
        step(0, 0, 2'b00, 0, 0, 0, "R3 stays clear");
        // r2_ oscillator leads, high current
        step(0, 0, 2'b01, 0, 0, 0, "R4 high mode");
        step(0, 1, 2'b01, 0, 1, 0, "R2 osc leads");
        step(0, 0, 2'b01, 0, 1, 0, "R2 dn persists");
        step(1, 0, 2'b01, 1, 1, 0, "R1 ref edge joins");
        step(0, 0, 2'b01, 0, 0, 0, "R3 clear after osc lead");
        // simultaneous edges
        step(1, 1, 2'b00, 1, 1, 0, "R3 simultaneous edges");
        step(0, 0, 2'b00, 0, 0, 0, "R3 simultaneous clear");
        // edge in clearing cycle is lost
        step(1, 0, 2'b00, 1, 0, 0, "R1 ref edge");
        step(0, 1, 2'b00, 1, 1, 0, "R2 osc edge");
        step(1, 0, 2'b00, 0, 0, 0, "R3 edge during clear ignored");
        step(0, 0, 2'b00, 0, 0, 0, "R3 lost edge stays lost");
        // pump off: masking with state running
        step(0, 0, 2'b10, 0, 0, 0, "R5 mid mode, R7 osc toggle low");
        step(1, 0, 2'b10, 0, 0, 0, "R5 up masked");
        step(0, 0, 2'b00, 1, 0, 0, "R5 hidden up reappears");
        step(0, 1, 2'b10, 0, 0, 1, "R5 pair masked, R7 osc toggle");
        step(0, 0, 2'b00, 0, 0, 0, "R5 hidden pair cleared");
        step(0, 1, 2'b10, 0, 0, 0, "R7 osc toggle falls");
        step(0, 0, 2'b10, 0, 0, 0, "R7 osc toggle held");
        step(0, 1, 2'b10, 0, 0, 1, "R7 osc toggle rises");
        // open mode: clamp and reference test signal
        step(1, 0, 2'b11, 1, 1, 1, "R6 open mode, R7 ref toggle");
        step(0, 0, 2'b11, 0, 0, 1, "R3 clear in open mode");
        step(1, 0, 2'b11, 1, 0, 0, "R7 ref toggle falls");
        step(0, 1, 2'b11, 1, 1, 0, "R2 osc edge in open mode");
        step(0, 0, 2'b11, 0, 0, 0, "R9 one-edge clear");
        step(0, 0, 2'b00, 0, 0, 0, "R7 test quiet in low mode");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule